// File: doc/BRIEF.md
# Byte-Read Signal Word Queue

This block buffers 16-bit signal words that a bus-side agent delivers, and lets the host CPU take them out through byte-wide I/O reads. The oldest stored word is always on view. The host reads its high half at one address and its low half at another. Only the low-half read removes the word. A host can therefore look at the high half as often as it likes, and finish with the low half to consume the entry.

Two more host addresses sit beside the data ports. One is a status byte, which shows whether the queue holds data, whether a word was lost, and whether the queue is full. The other is a control byte that holds an interrupt enable. A push that arrives while the queue is full is dropped, and the loss is remembered until the host reads the status byte. When enabled, the interrupt output is raised whenever the queue holds at least one word.

Top module: `sigq_top`

## Requirements
- R1: A host read at address 0 (`host_addr == 2'd0`) while the queue is not empty returns bits [7:0] of the oldest word on `host_rdata` in the cycle after the read, and removes that word.
- R2: A host read at address 1 returns bits [15:8] of the oldest word one cycle later, and leaves the queue contents and occupancy unchanged.
- R3: A read at address 0 or 1 while the queue is empty returns 8'hFF and removes nothing.
- R4: A push while the queue is full and no removal happens in the same cycle is dropped, and it sets the sticky `overflow` output. A host read at address 2 clears `overflow`. If a drop and that read fall in the same cycle, the flag stays set.
- R5: A push and a removal in the same cycle are both carried out. This holds with one entry stored and with the queue full, and in both cases the occupancy stays the same.
- R6: A read at address 2 returns a status byte: bit 0 set when the queue is not empty, bit 1 the overflow flag before the read, bit 2 set when the queue is full, and bits 7:3 zero.
- R7: A host write at address 3 stores `host_wdata[0]` as the interrupt enable, and a read at address 3 returns it in bit 0. `irq` is high exactly when the enable is set and the queue is not empty.
- R8: While `rst_n` is low at a clock edge, the queue is emptied and the overflow flag and the interrupt enable are cleared.
- R9: Words leave in the order they arrived. Up to DEPTH words are held, and `not_empty` is high exactly when at least one word is stored.
- R10: A read at address 1 followed by a read at address 0 yields the two halves of the same word, even when a push is accepted between the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Bus side offers a word this cycle |
| push_word | input | 16 | Signal word to store |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | 0 low byte, 1 high byte, 2 status, 3 control |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data, registered, valid the cycle after the strobe |
| not_empty | output | 1 | Queue holds at least one word |
| overflow | output | 1 | Sticky flag for a dropped push |
| irq | output | 1 | Not-empty interrupt gated by the enable |

## Verification
Every result is due one clock edge after the stimulus that causes it. The read data comes from a register loaded at the edge that samples the strobe. The occupancy, the flags and `irq` change at that same edge. The bench drives each stimulus at a falling edge and samples all outputs at the next falling edge, half a period after the edge. At that point it compares them with a queue model that has been advanced by exactly that one edge, so every check lands on the cycle in which the result must first appear.

// File: rtl/sigq_pkg.sv
// Package sigq_pkg
// Shared host address decode values and byte widths for the signal word queue.
// Assumes a two-bit host address space of four byte registers.
package sigq_pkg;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        HA_LOW  = 2'd0,
        HA_HIGH = 2'd1,
        HA_STAT = 2'd2,
        HA_CTRL = 2'd3
    } host_addr_e;

    localparam logic [BYTE_W-1:0] EMPTY_BYTE = 8'hFF;
endpackage

// File: rtl/sigq_store.sv
// Module sigq_store
// Circular word storage with read and write pointers and an occupancy count.
// A push is taken when there is room, or when a removal happens in the same
// cycle. A removal is taken only when a word is stored. The head word is
// presented combinationally from the read pointer.
// Assumes DEPTH >= 2. DEPTH need not be a power of two.
module sigq_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop_req,
    output logic [WORD_W-1:0] head_word,
    output logic              is_empty,
    output logic              is_full,
    output logic              push_drop,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push;
    logic              do_pop;

    // Next index with wrap at the last slot.
    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    // Decide which requests are carried out this cycle.
    always_comb begin
        is_empty  = (count == '0);
        is_full   = (count == FULL_LVL);
        do_pop    = pop_req && !is_empty;
        do_push   = push_req && (!is_full || do_pop);
        push_drop = push_req && is_full && !do_pop;
        head_word = mem[rd_ptr];
        level     = count;
    end

    // Write the pushed word into its slot.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_word;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sigq_host.sv
// Module sigq_host
// Host byte interface: decodes reads and writes, registers the read byte,
// keeps the sticky overflow flag and the interrupt enable.
// Assumes at most one of the read and write strobes is high per cycle.
// When both are high, both are carried out.
module sigq_host
    import sigq_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [7:0]        host_wdata,
    input  logic [WORD_W-1:0] head_word,
    input  logic              is_empty,
    input  logic              is_full,
    input  logic              push_drop,
    output logic              pop_req,
    output logic [7:0]        rdata,
    output logic              ovf_flag,
    output logic              irq_en
);
    host_addr_e addr;
    logic [7:0] rd_next;
    logic [7:0] stat_byte;
    logic       stat_rd;

    // Decode the address and build the status byte.
    always_comb begin
        addr      = host_addr_e'(host_addr);
        stat_byte = {5'b0, is_full, ovf_flag, !is_empty};
        stat_rd   = host_rd && (addr == HA_STAT);
        pop_req   = host_rd && (addr == HA_LOW);
    end

    // Select the byte returned for this read.
    always_comb begin
        case (addr)
            HA_LOW:  rd_next = is_empty ? EMPTY_BYTE : head_word[7:0];
            HA_HIGH: rd_next = is_empty ? EMPTY_BYTE : head_word[15:8];
            HA_STAT: rd_next = stat_byte;
            default: rd_next = {7'b0, irq_en};
        endcase
    end

    // Register the read byte one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (host_rd) begin
            rdata <= rd_next;
        end
    end

    // Sticky overflow: a drop sets it and wins over a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (push_drop) begin
            ovf_flag <= 1'b1;
        end else if (stat_rd) begin
            ovf_flag <= 1'b0;
        end
    end

    // Interrupt enable from the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (host_wr && (addr == HA_CTRL)) begin
            irq_en <= host_wdata[0];
        end
    end
endmodule

// File: rtl/sigq_top.sv
// Module sigq_top
// Signal word queue with a byte-wide host read side. The bus agent pushes
// 16-bit words. The host reads the high half at address 1 and the low half
// at address 0, and only the low-half read removes the word.
// Assumes a single clock domain and a synchronous active-low reset.
module sigq_top
    import sigq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    input  logic [15:0] push_word,
    input  logic        host_rd,
    input  logic        host_wr,
    input  logic [1:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    output logic        not_empty,
    output logic        overflow,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic [WORD_W-1:0] head_word;
    logic              is_empty;
    logic              is_full;
    logic              push_drop;
    logic              pop_req;
    logic              irq_en;
    logic [CW-1:0]     level;

    sigq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_valid),
        .push_word (push_word),
        .pop_req   (pop_req),
        .head_word (head_word),
        .is_empty  (is_empty),
        .is_full   (is_full),
        .push_drop (push_drop),
        .level     (level)
    );

    sigq_host #(.WORD_W(WORD_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .head_word  (head_word),
        .is_empty   (is_empty),
        .is_full    (is_full),
        .push_drop  (push_drop),
        .pop_req    (pop_req),
        .rdata      (host_rdata),
        .ovf_flag   (overflow),
        .irq_en     (irq_en)
    );

    // Drive the occupancy status and the gated interrupt.
    always_comb begin
        not_empty = !is_empty;
        irq       = irq_en && !is_empty;
    end
endmodule

// File: rtl/sigq_checker.sv
// Module sigq_checker
// Temporal properties of sigq_top, attached with bind below.
module sigq_checker #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       push_valid,
    input logic                       host_rd,
    input logic [1:0]                 host_addr,
    input logic                       not_empty,
    input logic                       overflow,
    input logic                       irq,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int CW = $clog2(DEPTH+1);
    logic lo_rd;
    logic hi_rd;
    assign lo_rd = host_rd && (host_addr == 2'd0);
    assign hi_rd = host_rd && (host_addr == 2'd1);

    assert_irq_needs_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> not_empty);

    assert_empty_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && host_rd && !push_valid) |=> !not_empty);

    assert_high_read_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd && !push_valid) |=> (level == $past(level)));

    assert_full_drop_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((level == CW'(DEPTH)) && push_valid && !lo_rd) |=> overflow);

    assert_push_pop_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && lo_rd && (level != '0)) |=> (level == $past(level)));

    assert_low_read_removes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd && !push_valid && (level != '0)) |=> (level == $past(level) - 1'b1));

    assert_reset_clears_R8: assert property (@(posedge clk)
        !rst_n |=> (level == '0 && !overflow));
endmodule

bind sigq_top sigq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .not_empty  (not_empty),
    .overflow   (overflow),
    .irq        (irq),
    .level      (level)
);

// File: tb/sigq_top_test.sv
module sigq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [15:0] push_word = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        not_empty;
    logic        overflow;
    logic        irq;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int mq[$];
    bit m_ovf = 0;
    bit m_en = 0;

    sigq_top #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_word(push_word),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .not_empty(not_empty),
        .overflow(overflow), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cycles);
            report();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One clock: drive at a falling edge, sample at the next falling edge.
    task automatic cyc(input bit pv, input int pw, input bit re, input int ra,
                       input bit we, input int wd, output int got);
        int exp_rd;
        bit popped;
        bit drop;
        string tag;
        exp_rd = 0;
        tag = "R1";
        case (ra)
            0: begin exp_rd = (mq.size() == 0) ? 'hFF : (mq[0] & 'hFF); tag = (mq.size() == 0) ? "R3" : "R1"; end
            1: begin exp_rd = (mq.size() == 0) ? 'hFF : (mq[0] >> 8); tag = (mq.size() == 0) ? "R3" : "R2"; end
            2: begin exp_rd = (mq.size() != 0) | (int'(m_ovf) << 1) | (int'(mq.size() == DEPTH) << 2); tag = "R6"; end
            default: begin exp_rd = int'(m_en); tag = "R7"; end
        endcase
        push_valid = pv; push_word = 16'(pw); host_rd = re; host_addr = 2'(ra);
        host_wr = we; host_wdata = 8'(wd);
        popped = re && ra == 0 && mq.size() != 0;
        drop = pv && mq.size() == DEPTH && !popped;
        if (popped) void'(mq.pop_front());
        if (pv && !drop) mq.push_back(pw & 'hFFFF);
        if (drop) m_ovf = 1;
        else if (re && ra == 2) m_ovf = 0;
        if (we && ra == 3) m_en = wd[0];
        @(negedge clk);
        got = host_rdata;
        push_valid = 0; host_rd = 0; host_wr = 0;
        if (re) chk(tag, host_rdata, exp_rd);
        chk("R9 not_empty", not_empty, mq.size() != 0);
        chk("R4 overflow", overflow, m_ovf);
        chk("R7 irq", irq, m_en && mq.size() != 0);
    endtask

    task automatic push(input int w);
        int g;
        cyc(1, w, 0, 0, 0, 0, g);
    endtask

    task automatic rd(input int a, output int g);
        cyc(0, 0, 1, a, 0, 0, g);
    endtask

    initial begin
        int g;
        int h;
        int l;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R8: reset state
        chk("R8 not_empty", not_empty, 0);
        chk("R8 overflow", overflow, 0);
        chk("R8 irq", irq, 0);
        rd(0, g); rd(1, g); rd(2, g); rd(3, g);   // R3 empty reads, R6, R7 defaults

        // R9/R1/R2: sweep every fill level, high read twice then low read
        for (int n = 1; n <= DEPTH; n++) begin
            for (int k = 0; k < n; k++) push('hA000 + n * 'h111 + k * 'h13);
            rd(2, g);
            for (int k = 0; k < n; k++) begin
                rd(1, h); rd(1, h); rd(0, l);
                chk("R9 order", (h << 8) | l, 'hA000 + n * 'h111 + k * 'h13);
            end
            rd(0, g);   // R3 empty after drain
        end

        // R4: overfill, status shows and clears overflow
        for (int k = 0; k < DEPTH + 2; k++) push('h5100 + k);
        rd(2, g);
        chk("R4 status byte", g, 'h07);
        rd(2, g);
        chk("R4 cleared", g, 'h05);
        // R4: drop and status read together keep the flag set
        cyc(1, 'h5199, 1, 2, 0, 0, g);
        chk("R4 set wins", overflow, 1);
        rd(2, g);
        // R5: push with removal at full is accepted
        cyc(1, 'h5200, 1, 0, 0, 0, g);
        chk("R5 full push+pop", overflow, 0);
        for (int k = 0; k < DEPTH; k++) rd(0, g);
        chk("R5 last word", g, 'h00);

        // R5: push and pop with one entry stored
        push('h1234);
        cyc(1, 'h5678, 1, 0, 0, 0, g);
        chk("R5 one-entry low", g, 'h34);
        chk("R5 one-entry level", not_empty, 1);
        rd(1, g);
        chk("R5 new head", g, 'h56);
        rd(0, g);

        // R10: push between high and low read
        push('hBEEF);
        rd(1, h);
        push('hCAFE);
        rd(0, l);
        chk("R10 consistent", (h << 8) | l, 'hBEEF);
        rd(0, g);

        // R7: enable gating
        push('h0101);
        chk("R7 gated off", irq, 0);
        cyc(0, 0, 0, 3, 1, 1, g);
        chk("R7 gated on", irq, 1);
        rd(3, g);
        chk("R7 readback", g, 1);
        rd(0, g);
        chk("R7 drained", irq, 0);
        push('h0202);

        // R8: reset mid-run
        push('h0303);
        cyc(1, 'h0404, 0, 0, 0, 0, g);
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        mq.delete(); m_ovf = 0; m_en = 0;
        chk("R8 emptied", not_empty, 0);
        chk("R8 irq off", irq, 0);
        rd(3, g);
        chk("R8 enable cleared", g, 0);
        rd(1, g);
        chk("R8 empty read", g, 'hFF);
        report();
    end
endmodule